// File: doc/BRIEF.md
# Buffered SPI Burst Host

This block is an SPI host that runs a whole burst of bytes without software taking part once the burst has begun. Software first fills a 320-byte command buffer through a simple synchronous register port. It then writes one control word that carries the byte count, a clock speed code, the clock mode, a device select and a force-select flag, with the GO bit set. The engine shifts the command bytes out on MOSI, most significant bit first. It samples MISO on every rising SCK edge and writes each received byte into a response buffer at the offset of the command byte sent alongside it.

At the end of a burst the engine sets a sticky completion event, which software clears by writing a one to it. The event drives an interrupt output unless a mask bit blocks it. Chip selects are active low, and at most one of them is driven. A force flag keeps the chosen select asserted from one burst to the next, so that a long exchange can span several bursts.

Register map (cfg_addr, byte granular): command buffer bytes at 0x000 to 0x13F (write only, data in cfg_wdata[7:0]); response buffer bytes at 0x200 to 0x33F (read only, data in cfg_rdata[7:0]); control at 0x3F0; event at 0x3F4; event mask at 0x3F8.

Top module: `spi_burst_host`

## Requirements
- R1: After reset every spi_csn line is high, spi_sck is low, irq is low, the control register reads 0, the event register reads 0 and the mask register reads 0x100.
- R2: A control write with bit 0 (GO) set and byte count N in bits 16:8 (N from 1 to 320) sends command bytes 0 to N-1 on spi_mosi, MSB first, with exactly 8N rising SCK edges. MOSI is stable at each rising edge.
- R3: The 8 bits sampled on spi_miso at the rising edges of byte i are stored, first bit as MSB, at response offset i and read back at address 0x200+i.
- R4: With speed code c in bits 7:5 and d = c for c of 2 or more (d = 2 for codes 0 and 1), rising SCK edges are exactly d clock cycles apart. Each high phase lasts floor(d/2) cycles.
- R5: Mode bit 2 sets the idle SCK level: 0 idles low (mode 0) and 1 idles high (mode 3). Data is sampled on the rising edge in both modes. SCK does not move while no burst runs.
- R6: Device select k in bits 27:25 drives only spi_csn[k] low, for k from 0 to 6. The value 7 drives no line, although the burst still runs.
- R7: The select line falls at least ceil(d/2) cycles before the first SCK edge. When force is clear it rises at least ceil(d/2) cycles after the last edge, and all lines are high whenever no burst runs.
- R8: With force (bit 4) set, the selected line stays low after the burst ends and through later bursts. A control write with force clear then releases it.
- R9: The end of a burst sets event bit 8. Writing 1 to that bit clears it. irq is high exactly while the event is set and mask bit 8 is 0. The mask resets to 1.
- R10: While a burst runs, control bits 1 (busy) and 0 (GO) read 1, and control writes are ignored. Both bits read 0 after the burst, and the fields read back as written.
- R11: A GO with byte count 0 sets the event at once, with no SCK edge and no select asserted.
- R12: A byte count above 320 runs as 320 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register and buffer byte address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (combinational from cfg_addr) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_csn | output | 7 | Active-low chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
Most internal faults in this engine reach the pins within one bit period. A wrong phase counter shows as a rising-edge spacing other than d in the very next period. A bit or byte counter off by one shows as a wrong rising-edge total, or as a shifted byte on MOSI and at the response offsets, by the end of the burst. A bad select or event path shows at once in the select lines or in the cycle after completion, through irq. The sweep crosses every speed code with both modes and every device select, and adds the single-byte, full-buffer, oversize, zero-length and forced-select cases.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;
  localparam int ADDR_W = 10;
  localparam int LEN_W  = 9;
  localparam int SPD_W  = 3;

  localparam logic [ADDR_W-1:0] RSP_BASE = 10'h200;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 10'h3F0;
  localparam logic [ADDR_W-1:0] EVT_ADDR = 10'h3F4;
  localparam logic [ADDR_W-1:0] MSK_ADDR = 10'h3F8;

  localparam int B_GO    = 0;
  localparam int B_BUSY  = 1;
  localparam int B_MODE  = 2;
  localparam int B_FORCE = 4;
  localparam int B_SPD   = 5;
  localparam int B_LEN   = 8;
  localparam int B_DEV   = 25;
  localparam int B_EVT   = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} burst_st_t;

  // Bit period in system clocks; codes below two share the fastest rate.
  function automatic logic [3:0] sck_div(input logic [SPD_W-1:0] code);
    if (code < 3'd2) return 4'd2;
    return {1'b0, code};
  endfunction

  function automatic logic [3:0] sck_hi(input logic [SPD_W-1:0] code);
    return sck_div(code) >> 1;
  endfunction

  function automatic logic [3:0] sck_lo(input logic [SPD_W-1:0] code);
    return sck_div(code) - sck_hi(code);
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] n,
                                                 input logic [LEN_W-1:0] lim);
    return (n > lim) ? lim : n;
  endfunction
endpackage

// File: rtl/spi_byte_ram.sv
`timescale 1ns/1ps
module spi_byte_ram #(
  parameter int DEPTH = 320,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_burst_fsm.sv
`timescale 1ns/1ps
module spi_burst_fsm
  import spi_burst_pkg::*;
#(
  parameter int BUF_BYTES = 320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [SPD_W-1:0] code_i,
  input  logic             mode_i,
  input  logic             idle_mode_i,
  input  logic             miso_i,
  input  logic [7:0]       cmd_byte_i,
  output logic [LEN_W-1:0] cmd_addr_o,
  output logic             rsp_we_o,
  output logic [LEN_W-1:0] rsp_addr_o,
  output logic [7:0]       rsp_byte_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] LIM = LEN_W'(BUF_BYTES);

  burst_st_t        st;
  logic [3:0]       tcnt, lo_q, hi_q;
  logic [LEN_W-1:0] len_q, byte_q;
  logic [2:0]       bit_q;
  logic             ph_q, sck_q, mode_q, done_q;
  logic [7:0]       rx_q;

  wire tick      = (tcnt == 4'd0);
  wire byte_end  = (st == ST_SHIFT) && ph_q && tick && (bit_q == 3'd7);
  wire last_byte = (byte_q == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; tcnt <= '0; lo_q <= '0; hi_q <= '0;
      len_q <= '0; byte_q <= '0; bit_q <= '0; ph_q <= 1'b0;
      sck_q <= 1'b0; mode_q <= 1'b0; done_q <= 1'b0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          st     <= ST_LEAD;
          lo_q   <= sck_lo(code_i);
          hi_q   <= sck_hi(code_i);
          tcnt   <= sck_lo(code_i) - 4'd1;
          len_q  <= clamp_len(len_i, LIM);
          byte_q <= '0;
          bit_q  <= '0;
          mode_q <= mode_i;
          sck_q  <= mode_i;
        end
        ST_LEAD: if (tick) begin
          st <= ST_SHIFT; ph_q <= 1'b0; sck_q <= 1'b0; tcnt <= lo_q - 4'd1;
        end else tcnt <= tcnt - 4'd1;
        ST_SHIFT: if (!tick) tcnt <= tcnt - 4'd1;
        else if (!ph_q) begin
          ph_q <= 1'b1; sck_q <= 1'b1; rx_q <= {rx_q[6:0], miso_i};
          tcnt <= hi_q - 4'd1;
        end else if (bit_q == 3'd7 && last_byte) begin
          st <= ST_TRAIL; sck_q <= mode_q; tcnt <= lo_q - 4'd1;
        end else begin
          ph_q <= 1'b0; sck_q <= 1'b0; tcnt <= lo_q - 4'd1;
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) byte_q <= byte_q + LEN_W'(1);
        end
        ST_TRAIL: if (tick) begin
          st <= ST_IDLE; done_q <= 1'b1;
        end else tcnt <= tcnt - 4'd1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_addr_o = byte_q;
  assign rsp_we_o   = byte_end;
  assign rsp_addr_o = byte_q;
  assign rsp_byte_o = rx_q;
  assign mosi_o     = (st == ST_SHIFT) ? cmd_byte_i[~bit_q] : 1'b0;
  assign sck_o      = (st == ST_IDLE) ? idle_mode_i : sck_q;
  assign busy_o     = (st != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/spi_burst_host.sv
`timescale 1ns/1ps
module spi_burst_host
  import spi_burst_pkg::*;
#(
  parameter int BUF_BYTES = 320,
  parameter int NCS       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NCS-1:0]    spi_csn,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CMD_END = ADDR_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] RSP_END = ADDR_W'(RSP_BASE + ADDR_W'(BUF_BYTES));

  logic [2:0]       ctl_dev_q;
  logic [LEN_W-1:0] ctl_len_q;
  logic [SPD_W-1:0] ctl_spd_q;
  logic             ctl_force_q, ctl_mode_q, evt_q, msk_q;

  logic             run_busy, burst_done;
  logic [LEN_W-1:0] cmd_raddr, rsp_waddr;
  logic [7:0]       cmd_rbyte, rsp_wbyte, rsp_rbyte;
  logic             rsp_we;

  // Named events for the checker.
  wire ctl_wr      = cfg_we && (cfg_addr == CTL_ADDR);
  wire ctl_take    = ctl_wr && !run_busy;
  wire ctl_blocked = ctl_wr && run_busy;
  wire go_req      = ctl_take && cfg_wdata[B_GO];
  wire zero_go     = go_req && (cfg_wdata[B_LEN +: LEN_W] == '0);
  wire start_burst = go_req && !zero_go;
  wire evt_clr     = cfg_we && (cfg_addr == EVT_ADDR) && cfg_wdata[B_EVT];
  wire cs_drive    = run_busy || ctl_force_q;
  wire evt_bit     = evt_q;
  wire mask_bit    = msk_q;
  wire force_bit   = ctl_force_q;
  wire ctl_mode    = ctl_mode_q;
  wire [16:0] ctl_snapshot = {ctl_dev_q, ctl_len_q, ctl_spd_q, ctl_force_q, ctl_mode_q};

  wire cmd_hit = cfg_addr < CMD_END;
  wire rsp_hit = (cfg_addr >= RSP_BASE) && (cfg_addr < RSP_END);
  wire [ADDR_W-1:0] rsp_off = cfg_addr - RSP_BASE;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:28], cfg_wdata[24:17], cfg_wdata[3],
                         cfg_wdata[1], rsp_off[ADDR_W-1:LEN_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_dev_q <= '0; ctl_len_q <= '0; ctl_spd_q <= '0;
      ctl_force_q <= 1'b0; ctl_mode_q <= 1'b0;
      evt_q <= 1'b0; msk_q <= 1'b1;
    end else begin
      if (ctl_take) begin
        ctl_dev_q   <= cfg_wdata[B_DEV +: 3];
        ctl_len_q   <= cfg_wdata[B_LEN +: LEN_W];
        ctl_spd_q   <= cfg_wdata[B_SPD +: SPD_W];
        ctl_force_q <= cfg_wdata[B_FORCE];
        ctl_mode_q  <= cfg_wdata[B_MODE];
      end
      if (cfg_we && cfg_addr == MSK_ADDR) msk_q <= cfg_wdata[B_EVT];
      evt_q <= (evt_q && !evt_clr) || burst_done || zero_go;
    end
  end

  spi_byte_ram #(.DEPTH(BUF_BYTES), .AW(LEN_W)) u_cmd_ram (
    .clk(clk), .we(cfg_we && cmd_hit), .waddr(cfg_addr[LEN_W-1:0]),
    .wdata(cfg_wdata[7:0]), .raddr(cmd_raddr), .rdata(cmd_rbyte));

  spi_byte_ram #(.DEPTH(BUF_BYTES), .AW(LEN_W)) u_rsp_ram (
    .clk(clk), .we(rsp_we), .waddr(rsp_waddr), .wdata(rsp_wbyte),
    .raddr(rsp_off[LEN_W-1:0]), .rdata(rsp_rbyte));

  spi_burst_fsm #(.BUF_BYTES(BUF_BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_burst),
    .len_i(cfg_wdata[B_LEN +: LEN_W]), .code_i(cfg_wdata[B_SPD +: SPD_W]),
    .mode_i(cfg_wdata[B_MODE]), .idle_mode_i(ctl_mode_q), .miso_i(spi_miso),
    .cmd_byte_i(cmd_rbyte), .cmd_addr_o(cmd_raddr), .rsp_we_o(rsp_we),
    .rsp_addr_o(rsp_waddr), .rsp_byte_o(rsp_wbyte), .sck_o(spi_sck),
    .mosi_o(spi_mosi), .busy_o(run_busy), .done_o(burst_done));

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign spi_csn[k] = !(cs_drive && (ctl_dev_q == 3'(k)));
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == CTL_ADDR) begin
      cfg_rdata[B_DEV +: 3]       = ctl_dev_q;
      cfg_rdata[B_LEN +: LEN_W]   = ctl_len_q;
      cfg_rdata[B_SPD +: SPD_W]   = ctl_spd_q;
      cfg_rdata[B_FORCE]          = ctl_force_q;
      cfg_rdata[B_MODE]           = ctl_mode_q;
      cfg_rdata[B_BUSY]           = run_busy;
      cfg_rdata[B_GO]             = run_busy;
    end else if (cfg_addr == EVT_ADDR) cfg_rdata[B_EVT] = evt_q;
    else if (cfg_addr == MSK_ADDR) cfg_rdata[B_EVT] = msk_q;
    else if (rsp_hit) cfg_rdata[7:0] = rsp_rbyte;
  end

  assign irq = evt_q && !msk_q;
endmodule

// File: rtl/spi_burst_host_chk.sv
`timescale 1ns/1ps
module spi_burst_host_chk #(
  parameter int NCS = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           spi_sck,
  input logic [NCS-1:0] spi_csn,
  input logic           irq,
  input logic           run_busy,
  input logic           burst_done,
  input logic           evt_bit,
  input logic           ctl_blocked,
  input logic [16:0]    ctl_snapshot,
  input logic           ctl_mode,
  input logic           force_bit
);
  // R6: never more than one select driven
  p_cs_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_csn) <= 1);

  // R9: completion raises the event on the following cycle
  p_done_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> evt_bit);

  // R9: interrupt only with a pending event
  p_irq_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_bit);

  // R10: control writes during a burst leave the fields untouched
  p_ctl_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_blocked |=> $stable(ctl_snapshot));

  // R5: SCK stays put between bursts unless the mode is rewritten
  p_sck_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_busy && !$past(run_busy) && $stable(ctl_mode)) |-> $stable(spi_sck));

  // R7: every select released when idle without force
  p_cs_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_busy && !force_bit) |-> (&spi_csn));
endmodule

bind spi_burst_host spi_burst_host_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn), .irq(irq),
  .run_busy(run_busy), .burst_done(burst_done), .evt_bit(evt_bit),
  .ctl_blocked(ctl_blocked), .ctl_snapshot(ctl_snapshot),
  .ctl_mode(ctl_mode), .force_bit(force_bit));

// File: tb/tb_spi_burst_host.sv
`timescale 1ns/1ps
module tb_spi_burst_host;
  localparam int NCS = 7;
  localparam logic [9:0] A_RSP = 10'h200, A_CTL = 10'h3F0, A_EVT = 10'h3F4, A_MSK = 10'h3F8;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, spi_miso = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic spi_sck, spi_mosi, irq;
  logic [NCS-1:0] spi_csn;

  spi_burst_host #(.BUF_BYTES(320), .NCS(NCS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_csn(spi_csn), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int seed = 0, d_exp = 2, hi_exp = 1, lo_exp = 1;

  // Slave monitor state
  int cyc = 0, edges = 0, n_rise = 0, cs_falls = 0, cs_fall_cyc = 0, setup_cyc = 0;
  int last_edge = 0, last_rise = 0, per_bad = 0, high_bad = 0, hold_bad = 0;
  logic [NCS-1:0] lines_seen = '0, prev_csn = '1;
  logic prev_sck = 1'b0;
  logic [7:0] mosi_sh = '0;
  logic [7:0] mosi_bytes [512];

  function automatic logic [7:0] cmd_pat(int i, int s);
    return 8'((i * 13 + s * 7 + 1));
  endfunction
  function automatic logic [7:0] miso_pat(int i, int s);
    return 8'((i * 29 + s)) ^ 8'h5A;
  endfunction
  function automatic logic miso_bit(int k);
    logic [7:0] b;
    b = miso_pat(k / 8, seed);
    return b[7 - (k % 8)];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if ((spi_csn != '1) && (prev_csn == '1)) begin
        cs_falls++; cs_fall_cyc = cyc; spi_miso = miso_bit(0);
      end
      if ((spi_csn == '1) && (prev_csn != '1) && edges > 0 && (cyc - last_edge) < lo_exp)
        hold_bad++;
      lines_seen = lines_seen | ~spi_csn;
      if (spi_sck != prev_sck) begin
        edges++;
        if (edges == 1 && cs_falls > 0) setup_cyc = cyc - cs_fall_cyc;
        last_edge = cyc;
        if (spi_sck) begin
          if (n_rise > 0 && (cyc - last_rise) != d_exp) per_bad++;
          last_rise = cyc;
          mosi_sh = {mosi_sh[6:0], spi_mosi};
          n_rise++;
          if (n_rise % 8 == 0 && n_rise / 8 <= 512) mosi_bytes[n_rise / 8 - 1] = mosi_sh;
        end else if (n_rise > 0) begin
          if ((cyc - last_rise) != hi_exp) high_bad++;
          spi_miso = miso_bit(n_rise);
        end
      end
    end
    prev_sck = spi_sck;
    prev_csn = spi_csn;
  end

  task automatic bus_write(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  function automatic logic [31:0] ctl_word(int dev, int n, int spd, bit frc, bit md, bit go);
    return (32'(dev) << 25) | (32'(n) << 8) | (32'(spd) << 5) |
           (32'(frc) << 4) | (32'(md) << 2) | 32'(go);
  endfunction

  task automatic arm;
    @(posedge clk);
    edges = 0; n_rise = 0; cs_falls = 0; setup_cyc = 0; per_bad = 0;
    high_bad = 0; hold_bad = 0; lines_seen = '0;
    spi_miso = miso_bit(0);
  endtask

  task automatic run_burst(int n, int spd, bit md, int dev, bit frc, int sd);
    logic [31:0] v, cw;
    int ne, bad, first_bad, rd;
    logic [NCS-1:0] exp_lines;
    ne = (n > 320) ? 320 : n;
    seed = sd;
    d_exp = (spd < 2) ? 2 : spd;
    hi_exp = d_exp / 2;
    lo_exp = d_exp - hi_exp;
    exp_lines = (dev < NCS) ? NCS'(1 << dev) : '0;
    for (int i = 0; i < ne; i++) bus_write(10'(i), 32'(cmd_pat(i, sd)));
    cw = ctl_word(dev, n % 512, spd, frc, md, 1'b0);
    bus_write(A_CTL, cw);
    repeat (3) @(negedge clk);
    chk(spi_sck == md, "R5 idle level", int'(spi_sck), int'(md));
    arm();
    bus_write(A_CTL, cw | 32'h1);
    bus_read(A_CTL, v);
    chk(v[1:0] == 2'b11, "R10 busy bits", int'(v[1:0]), 3);
    bus_write(A_CTL, ctl_word((dev + 1) % 8, 5, 7, ~frc, ~md, 1'b0));
    rd = 0;
    while (!irq && rd < 60000) begin @(negedge clk); rd++; end
    chk(irq, "R9 irq on completion", int'(irq), 1);
    chk(n_rise == 8 * ne, (n > 320) ? "R12 clamped edges" : "R2 rising edges", n_rise, 8 * ne);
    bad = 0; first_bad = -1;
    for (int i = 0; i < ne; i++)
      if (mosi_bytes[i] != cmd_pat(i, sd)) begin bad++; if (first_bad < 0) first_bad = i; end
    chk(bad == 0, "R2 mosi bytes", first_bad, -1);
    bad = 0; first_bad = -1;
    for (int i = 0; i < ne; i++) begin
      bus_read(A_RSP + 10'(i), v);
      if (v[7:0] != miso_pat(i, sd)) begin bad++; if (first_bad < 0) first_bad = i; end
    end
    chk(bad == 0, "R3 response offsets", first_bad, -1);
    chk(per_bad == 0 && high_bad == 0, "R4 sck timing", per_bad + high_bad, 0);
    if (cs_falls > 0) chk(setup_cyc >= lo_exp, "R7 select setup", setup_cyc, lo_exp);
    chk(hold_bad == 0, "R7 select hold", hold_bad, 0);
    chk(lines_seen == exp_lines, "R6 selected line", int'(lines_seen), int'(exp_lines));
    bus_read(A_CTL, v);
    chk(v == cw, "R10 fields kept, busy clear", int'(v), int'(cw));
    chk(spi_sck == md, "R5 sck back at idle", int'(spi_sck), int'(md));
    if (frc) chk(spi_csn == ~exp_lines, "R8 select held", int'(spi_csn), int'(~exp_lines));
    else chk(spi_csn == '1, "R7 select released", int'(spi_csn), 'h7F);
    bus_write(A_EVT, 32'h100);
    @(negedge clk);
    chk(!irq, "R9 event cleared", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual 0 expected 1");
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_csn == '1, "R1 csn", int'(spi_csn), 'h7F);
    chk(spi_sck == 1'b0 && irq == 1'b0, "R1 sck irq", int'({spi_sck, irq}), 0);
    bus_read(A_CTL, v); chk(v == 0, "R1 control", int'(v), 0);
    bus_read(A_EVT, v); chk(v == 0, "R1 event", int'(v), 0);
    bus_read(A_MSK, v); chk(v == 32'h100, "R1 mask", int'(v), 'h100);

    // Zero-length GO: event at once, nothing on the wire
    arm();
    bus_write(A_CTL, ctl_word(2, 0, 4, 1'b0, 1'b0, 1'b1));
    repeat (10) @(negedge clk);
    bus_read(A_EVT, v); chk(v[8], "R11 event set", int'(v), 'h100);
    chk(edges == 0 && cs_falls == 0, "R11 no activity", edges + cs_falls, 0);
    chk(!irq, "R9 masked irq", int'(irq), 0);
    bus_write(A_MSK, 32'h0);
    @(negedge clk); chk(irq, "R9 unmasked irq", int'(irq), 1);
    bus_write(A_EVT, 32'h100);
    @(negedge clk); chk(!irq, "R9 write one clears", int'(irq), 0);

    // Sweep every speed code with both modes
    for (int spd = 0; spd < 8; spd++)
      for (int md = 0; md < 2; md++)
        run_burst(3, spd, md[0], (spd + md) % 7, 1'b0, spd * 2 + md);

    // Every device select including the unused value
    for (int dv = 0; dv < 8; dv++) run_burst(2, 3, dv[0], dv, 1'b0, 40 + dv);

    run_burst(1, 7, 1'b1, 4, 1'b0, 60);
    // Forced select held across bursts, then released
    run_burst(2, 2, 1'b0, 5, 1'b1, 61);
    run_burst(3, 5, 1'b0, 5, 1'b1, 62);
    bus_write(A_CTL, ctl_word(5, 3, 5, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    chk(spi_csn == '1, "R8 force cleared releases", int'(spi_csn), 'h7F);

    run_burst(320, 2, 1'b0, 0, 1'b0, 70);
    run_burst(511, 2, 1'b1, 1, 1'b0, 71);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule